// File: doc/BRIEF.md
# Clear-on-read interrupt status controller

This block gathers single-cycle event pulses from the rest of a network controller into one 32-bit status word, filters them through a host-programmable mask, and drives one interrupt line toward the host. The host reads the status word through a simple register port. That read returns the current bits and clears them in the same access, so no separate acknowledge is needed. An event that lands on the exact cycle of the clearing read is kept for the next read.

One position, bit 23, does not belong to this register. It mirrors a level interrupt from the management sub-block, which the host clears by servicing that sub-block. The bit shows the live level. A status read leaves it alone and the mask cannot hide it. Two extra outputs summarise the pending bits as fatal or non-fatal, whatever the mask holds, so recovery logic can act without decoding the word.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status bits are all 0, the mask reads 0xFF7FFFFF, and irq_o, fatal_o and nonfatal_o are low while mgmt_irq_i is low.
- R2: A one-cycle pulse on evt_i[i], for i not equal to 23, sets status bit i at the next clock edge, and the bit stays set until a status read.
- R3: A status read (reg_rd_i high, reg_sel_i = 0) drives the current status on reg_rdata_o in that cycle and clears every status bit except bit 23 at the closing clock edge.
- R4: An event pulse that coincides with a status read is not part of that read's data, and its bit is set after the read.
- R5: Status bit 23 always shows the level of mgmt_irq_i, a status read does not clear it, and evt_i[23] has no effect.
- R6: A mask write (reg_wr_i high, reg_sel_i = 1) loads reg_wdata_i into the mask, except bit 23, which always reads 0. A mask read (reg_rd_i high, reg_sel_i = 1) returns the mask.
- R7: irq_o is high when any status bit with a mask bit of 0 is set, and is always high while mgmt_irq_i is high.
- R8: fatal_o is high when any status bit in 0xFC7C0000 is set. nonfatal_o is high when any status bit in 0x0002FEFC is set. The mask has no effect on either.
- R9: A write with reg_sel_i = 0 changes neither the status bits nor the mask.
- R10: reg_rdata_o is 0 in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one bit per status position |
| mgmt_irq_i | input | 1 | Level interrupt from the management sub-block |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Interrupt to the host |
| fatal_o | output | 1 | A fatal-class status bit is pending |
| nonfatal_o | output | 1 | A non-fatal-class status bit is pending |

## Verification
The bench drives an event pulse in the same cycle as a clearing read. A design that let the clear win would lose that event, and the second read would return 0. The bench holds the management level high across two status reads and under an all-ones mask. A design that stored bit 23 like the other bits, or let the mask cover it, would drop the bit on the second read or hold irq_o low. The bench writes all ones to the mask and to the status select. Mask bit 23 must read back as 0 and the status word must stay empty, so a write decoder that ignores the select or the pinned bit is caught. The summary flags are checked with bits that the default mask hides, so a design that gates them with the mask would leave them low.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [31:0] mask;
    } mask_state_t;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int WIDTH    = 32,
    parameter int PASS_BIT = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             mgmt_irq_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] status_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == PASS_BIT) begin : g_pass
            // live level from the management block; not stored here
            logic unused_pass_evt;
            assign unused_pass_evt = evt_i[i];
            assign status_o[i]     = mgmt_irq_i;
        end else begin : g_sticky
            logic bit_d;
            logic bit_q;

            always_comb begin
                bit_d = bit_q;
                if (clr_i) begin
                    bit_d = 1'b0;
                end
                // a coincident event wins over the clear
                if (evt_i[i]) begin
                    bit_d = 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else begin
                    bit_q <= bit_d;
                end
            end

            assign status_o[i] = bit_q;

            // R2 R4
            evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[i] |=> status_o[i]);

            // R3
            read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && !evt_i[i]) |=> !status_o[i]);

            // R2
            bit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (status_o[i] && !clr_i) |=> status_o[i]);
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_stat_pkg::*;
#(
    parameter int          WIDTH    = 32,
    parameter int          PASS_BIT = 23,
    parameter logic [31:0] MASK_RST = 32'hFF7F_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mask_o
);

    localparam logic [WIDTH-1:0] PASS_ONEHOT = WIDTH'(1) << PASS_BIT;
    localparam logic [WIDTH-1:0] RST_VAL     = MASK_RST[WIDTH-1:0] & ~PASS_ONEHOT;

    mask_state_t st_d;
    mask_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.mask = 32'(wdata_i & ~PASS_ONEHOT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= 32'(RST_VAL);
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask[WIDTH-1:0];

    // R6
    mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((mask_o | PASS_ONEHOT) == ($past(wdata_i) | PASS_ONEHOT)));

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int          WIDTH        = 32,
    parameter logic [31:0] FATAL_SET    = 32'hFC7C_0000,
    parameter logic [31:0] NONFATAL_SET = 32'h0002_FEFC
) (
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_o,
    output logic             fatal_o,
    output logic             nonfatal_o
);

    localparam logic [WIDTH-1:0] FATAL_V = FATAL_SET[WIDTH-1:0];
    localparam logic [WIDTH-1:0] NONF_V  = NONFATAL_SET[WIDTH-1:0];

    always_comb begin
        irq_o      = |(status_i & ~mask_i);
        fatal_o    = |(status_i & FATAL_V);
        nonfatal_o = |(status_i & NONF_V);
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter int          WIDTH        = 32,
    parameter int          PASS_BIT     = 23,
    parameter logic [31:0] MASK_RST     = 32'hFF7F_FFFF,
    parameter logic [31:0] FATAL_SET    = 32'hFC7C_0000,
    parameter logic [31:0] NONFATAL_SET = 32'h0002_FEFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             mgmt_irq_i,
    input  logic             reg_rd_i,
    input  logic             reg_wr_i,
    input  logic             reg_sel_i,
    input  logic [WIDTH-1:0] reg_wdata_i,
    output logic [WIDTH-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic             fatal_o,
    output logic             nonfatal_o
);

    logic [WIDTH-1:0] status_w;
    logic [WIDTH-1:0] mask_w;
    logic             rd_status;
    logic             rd_mask;
    logic             wr_mask;

    always_comb begin
        rd_status = reg_rd_i && (reg_sel_e'(reg_sel_i) == SEL_STATUS);
        rd_mask   = reg_rd_i && (reg_sel_e'(reg_sel_i) == SEL_MASK);
        wr_mask   = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_MASK);
    end

    irq_status_bank #(
        .WIDTH    (WIDTH),
        .PASS_BIT (PASS_BIT)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .mgmt_irq_i (mgmt_irq_i),
        .clr_i      (rd_status),
        .status_o   (status_w)
    );

    irq_mask_reg #(
        .WIDTH    (WIDTH),
        .PASS_BIT (PASS_BIT),
        .MASK_RST (MASK_RST)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata_i),
        .mask_o  (mask_w)
    );

    irq_summary #(
        .WIDTH        (WIDTH),
        .FATAL_SET    (FATAL_SET),
        .NONFATAL_SET (NONFATAL_SET)
    ) u_sum (
        .status_i   (status_w),
        .mask_i     (mask_w),
        .irq_o      (irq_o),
        .fatal_o    (fatal_o),
        .nonfatal_o (nonfatal_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (rd_status) begin
            reg_rdata_o = status_w;
        end else if (rd_mask) begin
            reg_rdata_o = mask_w;
        end
    end

    // R7
    mgmt_irq_unmaskable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_irq_i |-> irq_o);

    // R8
    summary_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && (evt_i == '0)) |=> (!fatal_o && !nonfatal_o));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |-> (reg_rdata_o == '0));

endmodule

// File: tb/irq_status_ctrl_bench.sv
`timescale 1ns/1ps
module irq_status_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        mgmt_irq_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;
    logic        fatal_o;
    logic        nonfatal_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .mgmt_irq_i  (mgmt_irq_i),
        .reg_rd_i    (reg_rd_i),
        .reg_wr_i    (reg_wr_i),
        .reg_sel_i   (reg_sel_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o),
        .fatal_o     (fatal_o),
        .nonfatal_o  (nonfatal_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
        #1;
    endtask

    task automatic rd(input logic sel, output logic [31:0] data);
        @(negedge clk);
        reg_rd_i  = 1'b1;
        reg_sel_i = sel;
        #1;
        data = reg_rdata_o;
        @(negedge clk);
        reg_rd_i = 1'b0;
        #1;
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_i    = 1'b1;
        reg_sel_i   = sel;
        reg_wdata_i = data;
        @(negedge clk);
        reg_wr_i    = 1'b0;
        reg_wdata_i = '0;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 fatal", {31'b0, fatal_o}, 32'h0);
        check("R1 nonfatal", {31'b0, nonfatal_o}, 32'h0);
        rd(1'b1, d);
        check("R1 mask default", d, 32'hFF7F_FFFF);
        rd(1'b0, d);
        check("R1 status empty", d, 32'h0);
        check("R10 idle rdata", reg_rdata_o, 32'h0);
    endtask

    task automatic t_set_clear;
        logic [31:0] d;
        pulse(32'h0000_0001);
        check("R7 masked bit no irq", {31'b0, irq_o}, 32'h0);
        rd(1'b0, d);
        check("R2 bit set", d, 32'h0000_0001);
        rd(1'b0, d);
        check("R3 read cleared", d, 32'h0);
    endtask

    task automatic t_unmasked;
        logic [31:0] d;
        wr(1'b1, 32'hFFFF_FFFE);
        rd(1'b1, d);
        check("R6 mask readback", d, 32'hFF7F_FFFE);
        pulse(32'h0000_0002);
        check("R7 masked bit1 no irq", {31'b0, irq_o}, 32'h0);
        rd(1'b0, d);
        pulse(32'h0000_0001);
        check("R7 unmasked irq", {31'b0, irq_o}, 32'h1);
        rd(1'b0, d);
        check("R3 read value", d, 32'h0000_0001);
        check("R7 irq after clear", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_summary;
        logic [31:0] d;
        wr(1'b1, 32'hFFFF_FFFF);
        pulse(32'h8000_0000);
        check("R8 fatal set", {31'b0, fatal_o}, 32'h1);
        check("R8 nonfatal idle", {31'b0, nonfatal_o}, 32'h0);
        check("R7 fully masked", {31'b0, irq_o}, 32'h0);
        pulse(32'h0000_0004);
        check("R8 nonfatal set", {31'b0, nonfatal_o}, 32'h1);
        rd(1'b0, d);
        check("R3 two bits", d, 32'h8000_0004);
        check("R8 fatal cleared", {31'b0, fatal_o}, 32'h0);
        check("R8 nonfatal cleared", {31'b0, nonfatal_o}, 32'h0);
    endtask

    task automatic t_coincident;
        logic [31:0] d;
        @(negedge clk);
        reg_rd_i  = 1'b1;
        reg_sel_i = 1'b0;
        evt_i     = 32'h0000_0020;
        #1;
        d = reg_rdata_o;
        @(negedge clk);
        reg_rd_i = 1'b0;
        evt_i    = '0;
        #1;
        check("R4 not in read data", d, 32'h0);
        rd(1'b0, d);
        check("R4 event kept", d, 32'h0000_0020);
    endtask

    task automatic t_mgmt;
        logic [31:0] d;
        rd(1'b1, d);
        check("R6 bit23 unmaskable", d, 32'hFF7F_FFFF);
        @(negedge clk);
        mgmt_irq_i = 1'b1;
        #1;
        check("R7 mgmt irq", {31'b0, irq_o}, 32'h1);
        check("R8 mgmt not fatal", {31'b0, fatal_o}, 32'h0);
        rd(1'b0, d);
        check("R5 bit23 read", d, 32'h0080_0000);
        rd(1'b0, d);
        check("R5 bit23 not cleared", d, 32'h0080_0000);
        @(negedge clk);
        mgmt_irq_i = 1'b0;
        #1;
        check("R7 mgmt released", {31'b0, irq_o}, 32'h0);
        pulse(32'h0080_0000);
        rd(1'b0, d);
        check("R5 evt23 ignored", d, 32'h0);
    endtask

    task automatic t_status_write;
        logic [31:0] d;
        wr(1'b1, 32'h0000_0000);
        wr(1'b0, 32'hFFFF_FFFF);
        check("R9 no irq", {31'b0, irq_o}, 32'h0);
        rd(1'b0, d);
        check("R9 status untouched", d, 32'h0);
        rd(1'b1, d);
        check("R9 mask untouched", d, 32'h0);
        check("R10 idle rdata end", reg_rdata_o, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_set_clear();
        t_unmasked();
        t_summary();
        t_coincident();
        t_mgmt();
        t_status_write();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule